// File: doc/BRIEF.md
# Inter-Frame Forwarding Line Buffer

Two decoders work on consecutive frames of the same video. The upstream one writes the rows of its frame as it finishes them. The downstream one needs that frame as its motion-compensation reference. This block sits between them and keeps a circular buffer of the most recent pixel lines the upstream decoder has finished. It serves the downstream decoder's reference fetches from that buffer when it can. When it cannot, it hands the fetch to an off-chip read port.

Each fetch arrives as a block row, a block height, a start column and a width. The block widens the row range itself, adding two rows above and three rows below for the six-tap interpolation filter. The block also paces the two decoders:
- The downstream decoder is held while its widened range reaches rows that have not been produced yet (low watermark).
- The upstream decoder is held once it runs too far past the oldest row the downstream decoder still needs (high watermark).

The first decoder in a chain has no producer before it. A configuration input marks it, and every one of its fetches then goes off-chip.

Top module: `fwd_line_cache`

## Requirements
- R1: A line counts as produced when a write with `wr_last` set is accepted. Writes go into the line numbered by the count of lines produced so far. A served fetch returns exactly the words written for each of its rows and columns.
- R2: The held window runs from `max(0, P-LINES+1)` to `P-1`, where P is the produced count. The line in progress is not held. A fetch whose widened top row is below the window is a miss. A miss is accepted without waiting. In the cycle after acceptance, `ext_valid` is high for one cycle with the widened row range, the start column and the width.
- R3: The widened range is `lo = max(req_row-2, 0)` and `hi = min(req_row+req_h+2, FRAME_ROWS-1)`.
- R4: Let `need = min(hi+low_wm, FRAME_ROWS-1)`. A fetch that is not a miss and has `need >= P` is not accepted (`req_ready` low). `dn_stall` is a registered copy of that waiting condition, taken together with `req_valid`. It rises on the cycle after the condition appears and falls on the cycle after it clears.
- R5: `up_stall` is the registered value of `P >= keep_row + high_wm`. It is set on the cycle after that comparison becomes true and cleared on the cycle after it becomes false.
- R6: While `first_dec` is high, every fetch is a miss and `dn_stall` stays low.
- R7: After a hit is accepted at a clock edge, `pix_valid` rises one edge later. The words come one per cycle with no gaps: rows in ascending order, and within a row the columns in ascending order. `pix_last` marks the final word, and `pix_valid` falls after it.
- R8: `frame_start` sets the produced count to zero. A fetch made right after it waits for rows.
- R9: While a hit is being streamed, `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| first_dec | input | 1 | Marks the first decoder in the chain: all fetches go off-chip |
| low_wm | input | ROW_W | Extra rows the producer must be ahead of a fetch |
| high_wm | input | ROW_W | Maximum lead of the producer over `keep_row` |
| frame_start | input | 1 | Starts a new frame and sets the produced count to zero |
| wr_en | input | 1 | Upstream word write |
| wr_col | input | COL_W | Column of the written word |
| wr_data | input | PIX_W | Written word |
| wr_last | input | 1 | This write completes the current line |
| keep_row | input | ROW_W | Oldest row the downstream decoder still needs |
| up_stall | output | 1 | Hold for the upstream decoder |
| req_valid | input | 1 | Fetch request |
| req_row | input | ROW_W | Top row of the block |
| req_h | input | H_W | Block height in rows (at least 1) |
| req_col | input | COL_W | First column |
| req_w | input | COL_W+1 | Number of columns (at least 1) |
| req_ready | output | 1 | The fetch is accepted at this edge |
| dn_stall | output | 1 | Hold for the downstream decoder |
| pix_valid | output | 1 | Buffered word valid |
| pix_data | output | PIX_W | Buffered word |
| pix_last | output | 1 | Last word of the fetch |
| ext_valid | output | 1 | Off-chip fetch issued |
| ext_row_lo | output | ROW_W | Off-chip range, top row |
| ext_row_hi | output | ROW_W | Off-chip range, bottom row |
| ext_col | output | COL_W | Off-chip start column |
| ext_w | output | COL_W+1 | Off-chip width |

## Verification
The bench sweeps block rows over the whole frame at several fill levels of a small buffer, and computes the hit, miss and wait outcome of each fetch arithmetically.

The corner cases it targets are these:
- The window edge right after the buffer wraps. A design that counts the line in progress as held would return half-overwritten data.
- The clamps of the margin at the top and bottom of the frame. Without them, the design would either wait forever for rows past the frame or report a wrapped range.
- The one-cycle rise and release of both stalls. A combinational or twice-registered stall shows up at the wrong edge.
- The first-decoder mode and the window reset at frame start. A design that ignored either would serve stale lines.

// File: rtl/fwd_line_cache.sv
module fwd_line_cache #(
  parameter int PIX_W      = 8,
  parameter int LINES      = 32,
  parameter int LINE_WORDS = 16,
  parameter int FRAME_ROWS = 720,
  parameter int H_W        = 5,
  localparam int ROW_W     = $clog2(FRAME_ROWS + 1),
  localparam int COL_W     = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_dec,
  input  logic [ROW_W-1:0] low_wm,
  input  logic [ROW_W-1:0] high_wm,
  input  logic             frame_start,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             wr_last,
  input  logic [ROW_W-1:0] keep_row,
  output logic             up_stall,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [H_W-1:0]   req_h,
  input  logic [COL_W-1:0] req_col,
  input  logic [COL_W:0]   req_w,
  output logic             req_ready,
  output logic             dn_stall,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_last,
  output logic             ext_valid,
  output logic [ROW_W-1:0] ext_row_lo,
  output logic [ROW_W-1:0] ext_row_hi,
  output logic [COL_W-1:0] ext_col,
  output logic [COL_W:0]   ext_w
);
  localparam int SLOT_W   = $clog2(LINES);
  localparam int EXT_W    = ROW_W + H_W + 2;
  localparam int ABOVE    = 2;
  localparam int BELOW    = 3;
  localparam int LAST_ROW = FRAME_ROWS - 1;

  logic [PIX_W-1:0] store [LINES*LINE_WORDS];
  logic [ROW_W-1:0] produced, oldest, lo, hi, need;
  logic [EXT_W-1:0] bot, reach;
  logic             miss, wait_rows, busy, s_end;
  logic [ROW_W-1:0] s_row, s_hi;
  logic [COL_W-1:0] s_col, s_c0, s_cend;

  assign oldest    = (produced >= ROW_W'(LINES)) ? produced - ROW_W'(LINES - 1) : '0;
  assign lo        = (req_row >= ROW_W'(ABOVE)) ? req_row - ROW_W'(ABOVE) : '0;
  assign bot       = EXT_W'(req_row) + EXT_W'(req_h) + EXT_W'(BELOW - 1);
  assign hi        = (bot > EXT_W'(LAST_ROW)) ? ROW_W'(LAST_ROW) : bot[ROW_W-1:0];
  assign reach     = EXT_W'(hi) + EXT_W'(low_wm);
  assign need      = (reach > EXT_W'(LAST_ROW)) ? ROW_W'(LAST_ROW) : reach[ROW_W-1:0];
  assign miss      = first_dec | (lo < oldest);
  assign wait_rows = ~miss & (need >= produced);
  assign req_ready = req_valid & ~busy & ~wait_rows;
  assign s_end     = (s_row == s_hi) && (s_col == s_cend);

  always_ff @(posedge clk) begin
    if (wr_en && produced < ROW_W'(FRAME_ROWS))
      store[{produced[SLOT_W-1:0], wr_col}] <= wr_data;
    pix_data <= store[{s_row[SLOT_W-1:0], s_col}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      produced  <= '0;
      up_stall  <= 1'b0;
      dn_stall  <= 1'b0;
      busy      <= 1'b0;
      pix_valid <= 1'b0;
      pix_last  <= 1'b0;
      ext_valid <= 1'b0;
      ext_row_lo <= '0;
      ext_row_hi <= '0;
      ext_col   <= '0;
      ext_w     <= '0;
      s_row     <= '0;
      s_hi      <= '0;
      s_col     <= '0;
      s_c0      <= '0;
      s_cend    <= '0;
    end else begin
      if (frame_start)
        produced <= '0;
      else if (wr_en && wr_last && produced < ROW_W'(FRAME_ROWS))
        produced <= produced + 1'b1;
      up_stall <= EXT_W'(produced) >= EXT_W'(keep_row) + EXT_W'(high_wm);
      dn_stall <= req_valid & wait_rows;

      ext_valid <= req_ready & miss;
      if (req_ready && miss) begin
        ext_row_lo <= lo;
        ext_row_hi <= hi;
        ext_col    <= req_col;
        ext_w      <= req_w;
      end

      pix_valid <= busy;
      pix_last  <= busy & s_end;
      if (req_ready && !miss) begin
        busy   <= 1'b1;
        s_row  <= lo;
        s_hi   <= hi;
        s_col  <= req_col;
        s_c0   <= req_col;
        s_cend <= req_col + COL_W'(req_w - 1'b1);
      end else if (busy) begin
        if (s_end) begin
          busy <= 1'b0;
        end else if (s_col == s_cend) begin
          s_col <= s_c0;
          s_row <= s_row + 1'b1;
        end else begin
          s_col <= s_col + 1'b1;
        end
      end
    end
  end
endmodule

module fwd_line_cache_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             first_dec,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             dn_stall,
  input logic             pix_valid,
  input logic             pix_last,
  input logic             ext_valid,
  input logic [ROW_W-1:0] ext_row_lo,
  input logic [ROW_W-1:0] ext_row_hi
);
  // R9
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R7
  last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_last |-> pix_valid);
  // R7
  stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_last |=> pix_valid);
  // R6
  first_never_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_dec |=> !dn_stall);
  // R2
  ext_range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ext_row_lo <= ext_row_hi);
  // R4
  stall_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stall |-> $past(req_valid));
endmodule

bind fwd_line_cache fwd_line_cache_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .first_dec(first_dec), .req_valid(req_valid),
  .req_ready(req_ready), .busy(busy), .dn_stall(dn_stall), .pix_valid(pix_valid),
  .pix_last(pix_last), .ext_valid(ext_valid), .ext_row_lo(ext_row_lo),
  .ext_row_hi(ext_row_hi)
);

// File: tb/sim_fwd_line_cache.sv
module sim_fwd_line_cache;
  localparam int LINES = 8, LW = 4, FR = 16, PW = 8, HW = 5;
  localparam int RW = $clog2(FR + 1), CW = $clog2(LW);

  logic clk = 0, rst_n = 0;
  logic first_dec = 0, frame_start = 0, wr_en = 0, wr_last = 0, req_valid = 0;
  logic [RW-1:0] low_wm = 0, high_wm = 15, keep_row = 0, req_row = 0;
  logic [CW-1:0] wr_col = 0, req_col = 0;
  logic [PW-1:0] wr_data = 0;
  logic [HW-1:0] req_h = 1;
  logic [CW:0]   req_w = 1;
  logic up_stall, req_ready, dn_stall, pix_valid, pix_last, ext_valid;
  logic [PW-1:0] pix_data;
  logic [RW-1:0] ext_row_lo, ext_row_hi;
  logic [CW-1:0] ext_col;
  logic [CW:0]   ext_w;

  int total = 0, bad = 0;
  int produced_m = 0, low_m = 0;
  bit first_m = 0;

  always #10 clk = ~clk;

  fwd_line_cache #(.PIX_W(PW), .LINES(LINES), .LINE_WORDS(LW), .FRAME_ROWS(FR), .H_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .first_dec(first_dec), .low_wm(low_wm), .high_wm(high_wm),
    .frame_start(frame_start), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
    .wr_last(wr_last), .keep_row(keep_row), .up_stall(up_stall), .req_valid(req_valid),
    .req_row(req_row), .req_h(req_h), .req_col(req_col), .req_w(req_w),
    .req_ready(req_ready), .dn_stall(dn_stall), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_last(pix_last), .ext_valid(ext_valid), .ext_row_lo(ext_row_lo),
    .ext_row_hi(ext_row_hi), .ext_col(ext_col), .ext_w(ext_w));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_row(input int r);
    for (int c = 0; c < LW; c++) begin
      wr_en = 1; wr_col = CW'(c); wr_data = PW'(r * 16 + c); wr_last = (c == LW - 1);
      @(negedge clk);
    end
    wr_en = 0; wr_last = 0;
    produced_m++;
  endtask

  task automatic try_req(input int r, input int h, input int col, input int w);
    int lo, hi, need, oldest;
    bit miss, stall;
    lo = (r >= 2) ? r - 2 : 0;
    hi = (r + h + 2 > FR - 1) ? FR - 1 : r + h + 2;
    need = (hi + low_m > FR - 1) ? FR - 1 : hi + low_m;
    oldest = (produced_m >= LINES) ? produced_m - LINES + 1 : 0;
    miss = first_m || (lo < oldest);
    stall = !miss && (need >= produced_m);
    req_row = RW'(r); req_h = HW'(h); req_col = CW'(col); req_w = (CW + 1)'(w);
    req_valid = 1;
    #1;
    chk(req_ready == !stall, "R4 R2 R3 ready", int'(req_ready), int'(!stall));
    if (stall || !req_ready) begin
      @(negedge clk);
      chk(dn_stall == 1, "R4 stall rise", int'(dn_stall), 1);
      req_valid = 0;
      @(negedge clk);
      chk(dn_stall == 0, "R4 stall release", int'(dn_stall), 0);
      return;
    end
    @(negedge clk);
    req_valid = 0;
    chk(dn_stall == 0, "R4 no stall", int'(dn_stall), 0);
    if (miss) begin
      chk(ext_valid == 1, "R2 miss issued", int'(ext_valid), 1);
      chk(ext_row_lo == RW'(lo), "R3 lo", int'(ext_row_lo), lo);
      chk(ext_row_hi == RW'(hi), "R3 hi", int'(ext_row_hi), hi);
      chk(ext_col == CW'(col) && ext_w == (CW + 1)'(w), "R2 cols", int'(ext_col), col);
      chk(pix_valid == 0, "R2 no stream", int'(pix_valid), 0);
      @(negedge clk);
      chk(ext_valid == 0, "R2 one pulse", int'(ext_valid), 0);
    end else begin
      chk(ext_valid == 0 && pix_valid == 0, "R7 first gap", int'(pix_valid), 0);
      for (int rr = lo; rr <= hi; rr++)
        for (int cc = col; cc < col + w; cc++) begin
          @(negedge clk);
          chk(pix_valid == 1, "R7 valid", int'(pix_valid), 1);
          chk(pix_data == PW'(rr * 16 + cc), "R1 data", int'(pix_data), rr * 16 + cc);
          chk(pix_last == (rr == hi && cc == col + w - 1), "R7 last", int'(pix_last),
              int'(rr == hi && cc == col + w - 1));
          if (rr == lo && cc == col) begin
            req_valid = 1; #1;
            chk(req_ready == 0, "R9 busy", int'(req_ready), 0);
            req_valid = 0;
          end
        end
      @(negedge clk);
      chk(pix_valid == 0, "R7 end", int'(pix_valid), 0);
    end
  endtask

  task automatic sweep(input int h, input int col, input int w);
    for (int r = 0; r < FR; r++) try_req(r, h, col, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(up_stall == 0 && dn_stall == 0, "R5 R4 reset stalls", int'(up_stall), 0);
    chk(pix_valid == 0 && ext_valid == 0, "R7 R2 reset outputs", int'(pix_valid), 0);

    for (int r = 0; r < 6; r++) write_row(r);
    sweep(1, 1, 2);
    sweep(2, 0, 4);
    for (int r = 6; r < 13; r++) write_row(r);
    sweep(1, 2, 2);
    sweep(2, 0, 1);
    low_m = 2; low_wm = 2;
    sweep(1, 0, 4);
    low_m = 0; low_wm = 0;
    for (int r = 13; r < 16; r++) write_row(r);
    sweep(2, 3, 1);
    first_m = 1; first_dec = 1;
    sweep(1, 1, 3);
    first_m = 0; first_dec = 0;

    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    produced_m = 0;
    try_req(0, 1, 0, 1);  // R8 window emptied
    keep_row = 0; high_wm = 3;
    @(negedge clk);
    chk(up_stall == 0, "R5 below mark", int'(up_stall), 0);
    write_row(0);
    write_row(1);
    chk(up_stall == 0, "R5 two rows", int'(up_stall), 0);
    write_row(2);
    chk(up_stall == 0, "R5 not yet", int'(up_stall), 0);
    @(negedge clk);
    chk(up_stall == 1, "R5 rise", int'(up_stall), 1);
    keep_row = 1;
    @(negedge clk);
    chk(up_stall == 0, "R5 release", int'(up_stall), 0);
    try_req(0, 1, 0, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule